// File: doc/BRIEF.md
# Programmable Counter/Timer with Square-Wave Output

This block is a 16-bit down-counter for a serial controller. A mode input picks one of two behaviours. In timer mode the block runs without stopping and produces a square wave. Each half of the wave lasts a number of clock cycles set by a programmable preload, so the wave can serve as a baud clock. Software picks the divisor as clock frequency / (32 × baud rate), rounded down to an integer. In counter mode the block counts down from the preload once. It raises a status flag at terminal count and then keeps counting, wrapping past zero, until it is told to stop.

A small byte-wide register port gives access to the block. Writes at two addresses load the two preload bytes. Reads at the same two addresses return the live count. Two further addresses have no storage behind them: a read at one of them is the start command, and a read at the other is the stop command. The block has two outputs. The ready bit is meant to feed an interrupt controller. The waveform pin carries either the square wave or the count-done level.

Top module: `cnt_tmr`

## Requirements
- R1: After reset the waveform output is high, ready is low, the count reads back 0xFFFF on both bytes, and the count holds its value until the first start command.
- R2: A write at address 0x4 loads the upper preload byte and a write at 0x5 loads the lower one. A read at 0x4 or 0x5 returns the upper or lower count byte on rdata_o in the cycle after the read strobe. A read of any other address, or a cycle with no read, gives 0x00 on rdata_o.
- R3: mode_i = 0 selects counter mode. In that mode, a read at 0xE (start) loads the count from the preload, clears ready and drives the output high. From then on the count drops by one each cycle.
- R4: In counter mode, the ready bit sets and the output goes low on the cycle in which a decrement yields 0x0000. Counting then continues and wraps through 0xFFFF, and the output stays low and ready stays set.
- R5: In counter mode, a read at 0xF (stop) freezes the count, drives the output high and clears ready.
- R6: In counter mode, a preload write during a count does not change that count. Each start uses the latest preload, and a start with no write in between reuses the previous preload.
- R7: mode_i = 1 selects timer mode. After a start the output is high and then toggles every P cycles, where P is the preload, without ever stopping.
- R8: In timer mode, a preload write leaves the half-period in progress unchanged. The new value sets the length of the half-periods that follow.
- R9: In timer mode, ready sets on each low-to-high toggle, which is once per full wave cycle. A stop command clears ready and leaves the wave running.
- R10: In timer mode, a start during a cycle abandons that cycle: the output returns high and a new half-period of P cycles begins.
- R11: In timer mode, a preload of 0 gives a half-period of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = counter mode, 1 = timer mode |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ready_o | output | 1 | Terminal-count / cycle-complete status |
| wave_o | output | 1 | Square wave or count-done level |

## Verification
The assertions check the following on every clock cycle:
- a start loads the preload, drives the output high and clears ready;
- the count decrements by one each cycle while counter mode is running;
- at a timer reload, the value taken is the preload present at that moment;
- the count holds while the block is idle;
- ready is clear after a stop;
- rdata_o is zero when no count byte is read.

Some behaviour can only be shown by the bench's scenarios and its cycle model, run under random bus traffic:
- the exact half-period lengths, including the 65536-cycle case for a preload of 0;
- a preload change that takes effect only at the next reload;
- ready rising once per full wave cycle;
- the wrap past terminal count;
- reuse of the preload across restarts.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] REG_LO    = 4'h5;  // lower byte; higher bytes sit below
  localparam logic [ADDR_W-1:0] CMD_START = 4'hE;
  localparam logic [ADDR_W-1:0] CMD_STOP  = 4'hF;

  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_TIMER = 1'b1
  } ct_mode_e;
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CW-1:0]     count_i,
  output logic [CW-1:0]     preload_o,
  output logic [DW-1:0]     rdata_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam int NB = CW / DW;

  logic [NB-1:0] rd_hit;
  logic [DW-1:0] rd_mux;

  assign start_o = rd_en_i && (addr_i == CMD_START);
  assign stop_o  = rd_en_i && (addr_i == CMD_STOP);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = REG_LO - ADDR_W'(i);
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst) byte_q <= '0;
      else if (wr_en_i && addr_i == BADDR) byte_q <= wdata_i;
    end

    assign preload_o[i*DW +: DW] = byte_q;
    assign rd_hit[i] = rd_en_i && (addr_i == BADDR);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_hit[i]) rd_mux = rd_mux | count_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_hit == '0) |=> (rdata_o == '0)); // R2
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [CW-1:0] preload_i,
  output logic [CW-1:0] count_o,
  output logic          ready_o,
  output logic          wave_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  ct_mode_e      mode;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dec;
  logic          run_q;
  logic          rdy_q;
  logic          out_q;
  logic          adv;

  assign mode = ct_mode_e'(mode_i);
  assign dec  = cnt_q - ONE;
  // a stop halts the count only in counter mode
  assign adv  = run_q && !(stop_i && mode == MODE_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
      out_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= preload_i;
      run_q <= 1'b1;
      rdy_q <= 1'b0;
      out_q <= 1'b1;
    end else begin
      if (adv) begin
        if (mode == MODE_TIMER) begin
          if (dec == '0) begin
            cnt_q <= preload_i;         // next half-period uses the live preload
            out_q <= ~out_q;
            if (!out_q) rdy_q <= 1'b1;  // low-to-high ends a full cycle
          end else begin
            cnt_q <= dec;
          end
        end else begin
          cnt_q <= dec;
          if (dec == '0) begin
            rdy_q <= 1'b1;
            out_q <= 1'b0;
          end
        end
      end
      if (stop_i) begin
        rdy_q <= 1'b0;
        if (mode == MODE_COUNT) begin
          run_q <= 1'b0;
          out_q <= 1'b1;
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign ready_o = rdy_q;
  assign wave_o  = out_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == $past(preload_i) && out_q && !rdy_q)); // R3
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
    (run_q && mode == MODE_COUNT && !start_i && !stop_i) |=> (cnt_q == $past(cnt_q) - ONE)); // R4
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (run_q && mode == MODE_TIMER && !start_i && cnt_q == ONE) |=> (cnt_q == $past(preload_i))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> $stable(cnt_q)); // R1
  AST_STOP_CLR: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> !rdy_q); // R9
endmodule

// File: rtl/cnt_tmr.sv
module cnt_tmr
  import ct_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ready_o,
  output logic              wave_o
);
  logic [CW-1:0] preload;
  logic [CW-1:0] count;
  logic          start;
  logic          stop;

  ct_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .count_i   (count),
    .preload_o (preload),
    .rdata_o   (rdata_o),
    .start_o   (start),
    .stop_o    (stop)
  );

  ct_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .start_i   (start),
    .stop_i    (stop),
    .preload_i (preload),
    .count_o   (count),
    .ready_o   (ready_o),
    .wave_o    (wave_o)
  );
endmodule

// File: tb/sim_cnt_tmr.sv
`timescale 1ns/1ps
module sim_cnt_tmr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ready;
  logic       wave;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cnt_tmr u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .rd_en_i(rd), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .wave_o(wave)
  );

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  logic [15:0] m_cnt, m_pre;
  logic        m_run, m_rdy, m_out;
  logic [7:0]  m_rd;

  always @(posedge clk) begin
    logic st, sp, adv;
    logic [15:0] dec;
    if (rst) begin
      m_cnt = 16'hFFFF; m_pre = 16'h0; m_run = 0; m_rdy = 0; m_out = 1; m_rd = 0;
    end else begin
      st  = rd && addr == 4'hE;
      sp  = rd && addr == 4'hF;
      m_rd = (rd && addr == 4'h4) ? m_cnt[15:8] : (rd && addr == 4'h5) ? m_cnt[7:0] : 8'h00;
      dec = m_cnt - 16'd1;
      if (st) begin
        m_cnt = m_pre; m_run = 1; m_rdy = 0; m_out = 1;
      end else begin
        adv = m_run && !(sp && !mode);
        if (adv) begin
          if (mode) begin
            if (dec == 0) begin
              if (!m_out) m_rdy = 1;
              m_out = !m_out; m_cnt = m_pre;
            end else m_cnt = dec;
          end else begin
            m_cnt = dec;
            if (dec == 0) begin m_rdy = 1; m_out = 0; end
          end
        end
        if (sp) begin
          m_rdy = 0;
          if (!mode) begin m_run = 0; m_out = 1; end
        end
      end
      if (wr && addr == 4'h4) m_pre[15:8] = wdata;
      if (wr && addr == 4'h5) m_pre[7:0]  = wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(wave,  m_out, mode ? "R7 wave" : "R4 wave");
      chk(ready, m_rdy, mode ? "R9 ready" : "R4 ready");
      chk(rdata, m_rd,  "R2 rdata");
    end
  end

  // all tasks are entered at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    wr = 1; addr = a; wdata = d; @(negedge clk); wr = 0;
  endtask
  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    rd = 1; addr = a; @(negedge clk); rd = 0; v = rdata;
  endtask
  task automatic cmd(input logic [3:0] a);
    rd = 1; addr = a; @(negedge clk); rd = 0;
  endtask
  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (wave != lvl && n < 70000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int n;
    logic w;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(wave, 1, "R1 wave"); chk(ready, 0, "R1 ready");
    idle(5);
    rd_reg(4'h4, v); chk(v, 8'hFF, "R1 count hi");
    rd_reg(4'h5, v); chk(v, 8'hFF, "R1 count lo");
    rd_reg(4'h9, v); chk(v, 8'h00, "R2 other address");

    // counter mode
    mode = 0;
    wr_reg(4'h4, 8'h00); wr_reg(4'h5, 8'h05);
    cmd(4'hE);
    rd_reg(4'h5, v); chk(v, 8'h05, "R3 count after start");
    wr_reg(4'h5, 8'h09);                     // R6 write during count
    idle(10);
    chk(wave, 0, "R4 wave low after terminal"); chk(ready, 1, "R4 ready set");
    rd_reg(4'h4, v); chk(v, 8'hFF, "R4 wrapped hi byte");
    cmd(4'hF);
    chk(wave, 1, "R5 wave high"); chk(ready, 0, "R5 ready clear");
    rd_reg(4'h5, v); idle(3); rd_reg(4'h5, v2); chk(v2, v, "R5 count frozen");
    cmd(4'hE); rd_reg(4'h5, v); chk(v, 8'h09, "R6 new preload used");
    cmd(4'hF); cmd(4'hE); rd_reg(4'h5, v); chk(v, 8'h09, "R6 preload reused");
    cmd(4'hF);

    // timer mode
    mode = 1;
    wr_reg(4'h5, 8'h03);
    cmd(4'hE);
    chk(wave, 1, "R7 high after start");
    wait_level(0, n); chk(n, 3, "R7 first half");
    wait_level(1, n); chk(n, 3, "R7 second half");
    chk(ready, 1, "R9 ready per cycle");
    cmd(4'hF); chk(ready, 0, "R9 stop clears ready");
    w = wave; idle(3); chk(wave, !w, "R9 wave runs after stop");
    wait_level(0, n);
    cmd(4'hE); chk(wave, 1, "R10 restart high");
    wr_reg(4'h5, 8'h06);
    wait_level(0, n); chk(n, 2, "R8 current half kept");
    wait_level(1, n); chk(n, 6, "R8 new half applied");
    wr_reg(4'h5, 8'h00);
    cmd(4'hE);
    wait_level(0, n); chk(n, 65536, "R11 zero preload");

    // constrained random traffic, checked by the cycle model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] a;
      r = $urandom_range(0, 99);
      case ($urandom_range(0, 4))
        0: a = 4'h4; 1: a = 4'h5; 2: a = 4'hE; 3: a = 4'hF; default: a = 4'($urandom_range(0, 15));
      endcase
      if (r < 2) mode = ~mode;
      addr = a;
      rd = (r >= 10 && r < 30);
      wr = (r >= 30 && r < 45);
      wdata = (a == 4'h4) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(1, 40));
      @(negedge clk);
      rd = 0; wr = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule